// File: doc/BRIEF.md
# Adaptive/Escape Route Selector with Misroute Cap

This block makes the per-hop routing decision for one router of a two-dimensional mesh in which any router may be asleep. Sleeping routers still forward traffic over an always-on unidirectional ring, and each router has one designated output that continues that ring. The decision is taken from three things: the packet's head-flit state (its virtual-channel class and the number of off-path hops it has already made), its destination, and this router's coordinates, arrival port and the sleep flags of its four neighbours.

Adaptive packets prefer a powered-on neighbour that brings them closer to the destination. If every such neighbour is asleep, the packet is pushed along the ring. That push does not count as a detour when the ring output itself points toward the destination. Each real detour raises the packet's off-path count. Once that count reaches a set limit, the packet drops into the escape class for good. Escape packets follow the ring and nothing else. The result is registered and appears one cycle after the request.

Top module: `route_sel_top`

## Requirements
- R1: Outputs are registered. `rsp_valid` follows `req_valid` one clock later, and during reset `rsp_valid`, `out_port`, `out_class` and `out_mis` are all zero.
- R2: When the destination equals the router's coordinates, the port is local (code 0), and the class and count pass through unchanged, whatever the class is.
- R3: A packet arriving with class escape (`vc_class`=1) leaves on `ring_port` with class escape and an unchanged count. Neighbour sleep flags do not affect this.
- R4: An adaptive packet (`vc_class`=0) takes a powered-on neighbour that lies in a minimal direction. Port codes are: +X=1, −X=2, +Y=3, −Y=4. A neighbour in the X dimension is preferred over one in Y. The class and count are unchanged.
- R5: A minimal port equal to `in_port` is never chosen (no U-turn).
- R6: When no minimal neighbour is awake but `ring_port` lies in a minimal direction (and is not `in_port`), that port is chosen. The count is not increased and the class stays adaptive.
- R7: Otherwise the packet is misrouted to `ring_port` and its count is increased by one. It stays adaptive while the new count is below `MIS_THRESH` (default 2).
- R8: When a misroute brings the new count to `MIS_THRESH` or more, the outgoing class is escape.
- R9: The count saturates at 2^`MIS_W`−1 (7 by default) and never wraps.
- R10: Sleep flags of neighbours that are not in a minimal direction have no effect on the choice. Flag bit 0 is +X, bit 1 is −X, bit 2 is +Y and bit 3 is −Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| cur_x | input | XW | This router's X coordinate |
| cur_y | input | YW | This router's Y coordinate |
| dst_x | input | XW | Destination X |
| dst_y | input | YW | Destination Y |
| in_port | input | 3 | Port code the head flit arrived on |
| vc_class | input | 1 | 0 adaptive, 1 escape |
| mis_cnt | input | MIS_W | Off-path hops taken so far |
| nbr_off | input | 4 | Neighbour asleep flags |
| ring_port | input | 3 | Port code continuing the ring |
| rsp_valid | output | 1 | Decision valid |
| out_port | output | 3 | Chosen output port code |
| out_class | output | 1 | Class for the next hop |
| out_mis | output | MIS_W | Updated off-path count |

## Verification
Two events can coincide in the same cycle: the count saturating, and the threshold being crossed. Both happen when an adaptive packet that already holds the maximum count is misrouted. The bench provokes this with a count of 7 and a blocked minimal path. The result is judged correct only if the count stays at 7 and the class turns escape in the same response. The bench also drives the crossing case where the count goes from 1 to 2. In that case the class must flip on exactly that hop, while the count still increments normally.

// File: rtl/route_sel_pkg.sv
package route_sel_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_XPOS  = 3'd1,
    PORT_XNEG  = 3'd2,
    PORT_YPOS  = 3'd3,
    PORT_YNEG  = 3'd4
  } port_e;

  typedef enum logic {
    CLS_ADAPT = 1'b0,
    CLS_ESC   = 1'b1
  } cls_e;

  localparam int NUM_DIRS = 4;
endpackage

// File: rtl/route_sel_min_dirs.sv
module route_sel_min_dirs #(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output logic          at_dest,
  output logic [3:0]    min_mask
);
  // bit0 +X, bit1 -X, bit2 +Y, bit3 -Y
  function automatic logic [3:0] dir_mask(input logic [XW-1:0] cx, input logic [YW-1:0] cy,
                                          input logic [XW-1:0] dx, input logic [YW-1:0] dy);
    logic [3:0] m;
    m[0] = dx > cx;
    m[1] = dx < cx;
    m[2] = dy > cy;
    m[3] = dy < cy;
    return m;
  endfunction

  assign min_mask = dir_mask(cur_x, cur_y, dst_x, dst_y);
  assign at_dest  = (cur_x == dst_x) && (cur_y == dst_y);
endmodule

// File: rtl/route_sel_pick.sv
module route_sel_pick
  import route_sel_pkg::*;
(
  input  logic [3:0] min_mask,
  input  logic [3:0] nbr_off,
  input  logic [2:0] in_port,
  input  logic [2:0] ring_port,
  output logic       awake_hit,
  output logic [2:0] awake_port,
  output logic       ring_on_min
);
  logic [3:0] not_back;
  logic [3:0] cand;
  logic [3:0] ring_sel;

  for (genvar i = 0; i < NUM_DIRS; i++) begin : g_dir
    assign not_back[i] = (in_port != 3'(i + 1));
    assign ring_sel[i] = (ring_port == 3'(i + 1));
    assign cand[i]     = min_mask[i] & ~nbr_off[i] & not_back[i];
  end

  // Fixed priority: lowest index wins, so X directions precede Y.
  always_comb begin
    awake_port = PORT_LOCAL;
    for (int i = NUM_DIRS - 1; i >= 0; i--) begin
      if (cand[i]) awake_port = 3'(i + 1);
    end
  end

  assign awake_hit   = |cand;
  assign ring_on_min = |(ring_sel & min_mask & not_back);
endmodule

// File: rtl/route_sel_mis_update.sv
module route_sel_mis_update #(
  parameter int MIS_W      = 3,
  parameter int MIS_THRESH = 2
) (
  input  logic [MIS_W-1:0] cnt_in,
  output logic [MIS_W-1:0] cnt_next,
  output logic             over
);
  localparam logic [MIS_W-1:0] MIS_MAX = {MIS_W{1'b1}};

  function automatic logic [MIS_W-1:0] sat_inc(input logic [MIS_W-1:0] v);
    return (v == MIS_MAX) ? v : v + 1'b1;
  endfunction

  assign cnt_next = sat_inc(cnt_in);
  assign over     = int'(cnt_next) >= MIS_THRESH;
endmodule

// File: rtl/route_sel_top.sv
module route_sel_top
  import route_sel_pkg::*;
#(
  parameter int MESH_X     = 4,
  parameter int MESH_Y     = 4,
  parameter int MIS_W      = 3,
  parameter int MIS_THRESH = 2,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [XW-1:0]    cur_x,
  input  logic [YW-1:0]    cur_y,
  input  logic [XW-1:0]    dst_x,
  input  logic [YW-1:0]    dst_y,
  input  logic [2:0]       in_port,
  input  logic             vc_class,
  input  logic [MIS_W-1:0] mis_cnt,
  input  logic [3:0]       nbr_off,
  input  logic [2:0]       ring_port,
  output logic             rsp_valid,
  output logic [2:0]       out_port,
  output logic             out_class,
  output logic [MIS_W-1:0] out_mis
);
  localparam logic [MIS_W-1:0] MIS_MAX = {MIS_W{1'b1}};

  logic             at_dest;
  logic [3:0]       min_mask;
  logic             awake_hit;
  logic [2:0]       awake_port;
  logic             ring_on_min;
  logic [MIS_W-1:0] cnt_next;
  logic             over;
  logic             do_mis;
  logic [2:0]       nx_port;
  logic             nx_class;
  logic [MIS_W-1:0] nx_mis;

  route_sel_min_dirs #(.XW(XW), .YW(YW)) i_dirs (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .at_dest(at_dest), .min_mask(min_mask)
  );

  route_sel_pick i_pick (
    .min_mask(min_mask), .nbr_off(nbr_off), .in_port(in_port), .ring_port(ring_port),
    .awake_hit(awake_hit), .awake_port(awake_port), .ring_on_min(ring_on_min)
  );

  route_sel_mis_update #(.MIS_W(MIS_W), .MIS_THRESH(MIS_THRESH)) i_mis (
    .cnt_in(mis_cnt), .cnt_next(cnt_next), .over(over)
  );

  assign do_mis = !at_dest && (vc_class == CLS_ADAPT) && !awake_hit && !ring_on_min;

  always_comb begin
    nx_port  = ring_port;
    nx_class = vc_class;
    nx_mis   = mis_cnt;
    if (at_dest) begin
      nx_port = PORT_LOCAL;
    end else if (vc_class == CLS_ESC) begin
      nx_port = ring_port;
    end else if (awake_hit) begin
      nx_port = awake_port;
    end else if (ring_on_min) begin
      nx_port = ring_port;
    end else begin
      nx_mis   = cnt_next;
      nx_class = over ? CLS_ESC : CLS_ADAPT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      out_port  <= '0;
      out_class <= 1'b0;
      out_mis   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        out_port  <= nx_port;
        out_class <= nx_class;
        out_mis   <= nx_mis;
      end
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_LOCAL_EJECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && at_dest |=> out_port == PORT_LOCAL); // R2
  AST_ESC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vc_class && !at_dest |=> out_class && out_port == $past(ring_port)); // R3
  AST_NO_UTURN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !at_dest && (ring_port != in_port) |=> out_port != $past(in_port)); // R5
  AST_MIS_TO_ESC: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && do_mis && over |=> out_class == CLS_ESC); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_mis == $past(mis_cnt)) || (int'(out_mis) == int'($past(mis_cnt)) + 1)); // R7
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mis_cnt == MIS_MAX |=> out_mis == MIS_MAX); // R9
endmodule

// File: tb/test_route_sel_top.sv
`timescale 1ns/1ps
module test_route_sel_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
  logic [2:0] in_port = '0, ring_port = '0;
  logic vc_class = 1'b0;
  logic [2:0] mis_cnt = '0;
  logic [3:0] nbr_off = '0;
  logic rsp_valid;
  logic [2:0] out_port;
  logic out_class;
  logic [2:0] out_mis;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  route_sel_top i_route_sel_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .in_port(in_port), .vc_class(vc_class), .mis_cnt(mis_cnt),
    .nbr_off(nbr_off), .ring_port(ring_port),
    .rsp_valid(rsp_valid), .out_port(out_port), .out_class(out_class), .out_mis(out_mis)
  );

  typedef struct packed {
    logic [1:0] cx, cy, dx, dy;
    logic [2:0] inp;
    logic       cls;
    logic [2:0] mis;
    logic [3:0] off;
    logic [2:0] ring;
    logic [2:0] e_port;
    logic       e_cls;
    logic [2:0] e_mis;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1,2'd1,2'd1,2'd1,3'd2,1'b1,3'd3,4'b0000,3'd1, 3'd0,1'b1,3'd3, 8'd2},  // R2
    '{2'd1,2'd1,2'd3,2'd3,3'd0,1'b1,3'd4,4'b0000,3'd4, 3'd4,1'b1,3'd4, 8'd3},  // R3
    '{2'd1,2'd1,2'd3,2'd2,3'd0,1'b0,3'd0,4'b0000,3'd3, 3'd1,1'b0,3'd0, 8'd4},  // R4
    '{2'd1,2'd1,2'd0,2'd3,3'd0,1'b0,3'd0,4'b0000,3'd1, 3'd2,1'b0,3'd0, 8'd4},  // R4
    '{2'd1,2'd1,2'd0,2'd3,3'd0,1'b0,3'd0,4'b0010,3'd1, 3'd3,1'b0,3'd0, 8'd4},  // R4
    '{2'd1,2'd1,2'd1,2'd0,3'd0,1'b0,3'd0,4'b0000,3'd1, 3'd4,1'b0,3'd0, 8'd4},  // R4
    '{2'd1,2'd1,2'd3,2'd3,3'd1,1'b0,3'd0,4'b0000,3'd2, 3'd3,1'b0,3'd0, 8'd5},  // R5
    '{2'd1,2'd1,2'd3,2'd3,3'd0,1'b0,3'd1,4'b0101,3'd3, 3'd3,1'b0,3'd1, 8'd6},  // R6
    '{2'd1,2'd1,2'd3,2'd1,3'd0,1'b0,3'd0,4'b0001,3'd3, 3'd3,1'b0,3'd1, 8'd7},  // R7
    '{2'd1,2'd1,2'd3,2'd1,3'd0,1'b0,3'd1,4'b0001,3'd3, 3'd3,1'b1,3'd2, 8'd8},  // R8
    '{2'd1,2'd1,2'd3,2'd1,3'd0,1'b0,3'd7,4'b0001,3'd3, 3'd3,1'b1,3'd7, 8'd9},  // R9
    '{2'd1,2'd1,2'd3,2'd1,3'd0,1'b0,3'd0,4'b1110,3'd4, 3'd1,1'b0,3'd0, 8'd10}, // R10
    '{2'd1,2'd1,2'd3,2'd3,3'd0,1'b0,3'd0,4'b0000,3'd3, 3'd1,1'b0,3'd0, 8'd4},  // R4
    '{2'd1,2'd1,2'd0,2'd0,3'd0,1'b1,3'd2,4'b1111,3'd1, 3'd1,1'b1,3'd2, 8'd3}   // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 out_port", out_port, 0);
    check("R1 out_class", out_class, 0);
    check("R1 out_mis", out_mis, 0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      cur_x = VECS[k].cx; cur_y = VECS[k].cy; dst_x = VECS[k].dx; dst_y = VECS[k].dy;
      in_port = VECS[k].inp; vc_class = VECS[k].cls; mis_cnt = VECS[k].mis;
      nbr_off = VECS[k].off; ring_port = VECS[k].ring; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R%0d vec%0d valid", VECS[k].req, k), rsp_valid, 1);
      check($sformatf("R%0d vec%0d port", VECS[k].req, k), out_port, VECS[k].e_port);
      check($sformatf("R%0d vec%0d class", VECS[k].req, k), out_class, VECS[k].e_cls);
      check($sformatf("R%0d vec%0d count", VECS[k].req, k), out_mis, VECS[k].e_mis);
    end
    // R1: no request, no response one cycle later
    @(negedge clk);
    check("R1 idle valid", rsp_valid, 0);
    // R1: back-to-back requests, each answered the next cycle
    cur_x = 2'd2; cur_y = 2'd2; dst_x = 2'd2; dst_y = 2'd0; in_port = 3'd0;
    vc_class = 1'b0; mis_cnt = 3'd0; nbr_off = 4'b0000; ring_port = 3'd1; req_valid = 1'b1;
    @(negedge clk);
    check("R1 b2b first port", out_port, 4);
    dst_x = 2'd0; dst_y = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 b2b second port", out_port, 2);
    check("R1 b2b valid", rsp_valid, 1);
    @(negedge clk);
    check("R1 b2b drop", rsp_valid, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule